// File: doc/BRIEF.md
# Timestamped Transition History Recorder

This block keeps a history of how a wide vector of per-channel status codes changes over time. Each clock cycle it compares the incoming vector with the vector seen one cycle earlier. When recording is enabled and the two differ, it builds a record from the full vector and a free-running cycle timestamp. Quiet cycles cost no storage, so a large external memory can hold a long history.

Records queue in a small FIFO. A two-state write sequencer, `WR_IDLE` and `WR_BURST`, takes them from the FIFO and writes each one as a burst of 32-bit words to an external memory. On `WR_IDLE -> WR_BURST` it pops the FIFO head into a holding register while the FIFO is not empty. On `WR_BURST -> WR_IDLE` the memory has accepted the last word of the record. The write address runs around the memory as a ring, so the newest records overwrite the oldest.

A host reads the memory through its own path. It uses the current write address and a sticky wrap flag to find the oldest valid record. When a change arrives while the FIFO is full, the record is discarded and a saturating counter counts the loss.

Top module: `transition_recorder`

## Requirements
- R1: In the first clock cycle after reset is released with `rec_en` high, a record is always captured, whatever the vector holds.
- R2: While `rec_en` is high, a record is captured in a cycle only when `state_in` differs from its value in the previous cycle. An unchanged vector produces no memory write.
- R3: A record is WORDS*32 bits. Bits [STATE_W-1:0] hold the vector and the next TS_W bits hold the timestamp. The upper pad bits are zero. With defaults this is 80 + 40 + 8 = 128 bits. Word k of a record is bits [32k+31:32k] and is written to the k-th consecutive address, starting with k = 0.
- R4: The timestamp is a TS_W-bit count of clock cycles since reset release. It is 0 in the first cycle after reset and is sampled in the cycle the change is seen. It wraps silently at 2^TS_W.
- R5: The FIFO holds FIFO_DEPTH records and delivers them in capture order. `fifo_full` and `fifo_empty` report its occupancy and are never both high.
- R6: A change that arrives while `fifo_full` is high is discarded and adds one to `miss_count`, which saturates at all ones. `miss_count` never changes in a cycle where `fifo_full` was low.
- R7: `mem_addr` advances by one for each word the memory accepts (`mem_we` and `mem_ready` both high) and otherwise holds. After the last address it returns to zero.
- R8: `wrapped` rises when the address first returns from its last value to zero, and stays high until reset.
- R9: While `rec_en` is low, no record is captured. The previous-cycle vector keeps tracking `state_in`, so after re-enabling, only a difference from the vector of the cycle before counts as a change.
- R10: While `mem_we` is high and `mem_ready` is low, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timestamp tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_en | input | 1 | Recording enable |
| state_in | input | NUM_CH*CH_W | Combined channel status vector |
| mem_ready | input | 1 | Memory accepts the presented word this cycle |
| mem_we | output | 1 | A word is presented for writing |
| mem_addr | output | ADDR_W | Word address of the presented word |
| mem_wdata | output | 32 | Presented data word |
| fifo_full | output | 1 | Record FIFO is full |
| fifo_empty | output | 1 | Record FIFO is empty |
| miss_count | output | MISS_W | Saturating count of dropped records |
| wrapped | output | 1 | Write address has wrapped at least once |

## Verification
The bench starts recording straight out of reset. A design that waited for a first difference would lose the opening snapshot. It changes the vector every cycle while the memory stalls, to fill the FIFO. A design that accepted a push in the full cycle, or that did not count the drop, would show wrong record contents or a wrong `miss_count`. It writes more than one ring's worth of records into a small memory. An address that ran off the end, or a wrap flag that set one word early or late, shows up in the address and flag comparisons. It also toggles the vector with recording off and then re-enables it on an unchanged vector. A design that compared against a stale vector would emit a spurious record there.

// File: rtl/rec_pkg.sv
package rec_pkg;
    localparam int unsigned BUS_W = 32;

    typedef enum logic [0:0] {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_state_e;

    // number of bus words per record, rounded up to a power of two
    function automatic int unsigned words_for(input int unsigned bits);
        int unsigned raw;
        int unsigned p;
        raw = (bits + BUS_W - 1) / BUS_W;
        p = 1;
        while (p < raw) p = p * 2;
        return p;
    endfunction
endpackage

// File: rtl/rec_change_detect.sv
module rec_change_detect #(
    parameter int unsigned STATE_W = 80,
    parameter int unsigned TS_W    = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_en,
    input  logic [STATE_W-1:0] state_in,
    output logic               evt,
    output logic [TS_W-1:0]    ts
);
    logic [STATE_W-1:0] prev_q;
    logic               first_q;
    logic [TS_W-1:0]    ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            first_q <= 1'b1;
            ts_q    <= '0;
        end else begin
            ts_q   <= ts_q + 1'b1;
            prev_q <= state_in;
            if (rec_en) first_q <= 1'b0;
        end
    end

    assign evt = rec_en && (first_q || (state_in != prev_q));
    assign ts  = ts_q;
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
    parameter int unsigned W     = 120,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [DEPTH-1:0][W-1:0] store_q;
    logic [AW:0]             wp_q;
    logic [AW:0]             rp_q;
    logic                    do_push;
    logic                    do_pop;

    assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign empty   = (wp_q == rp_q);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = store_q[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store_q[wp_q[AW-1:0]] <= wr_data;
    end
endmodule

// File: rtl/rec_mem_writer.sv
module rec_mem_writer
    import rec_pkg::*;
#(
    parameter int unsigned IN_W   = 120,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [IN_W-1:0]   rec_data,
    output logic              pop,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    output logic              wrapped
);
    localparam int unsigned BEAT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int unsigned HOLD_W = WORDS * BUS_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

    wr_state_e           state_q;
    wr_state_e           state_d;
    logic [HOLD_W-1:0]   hold_q;
    logic [BEAT_W-1:0]   beat_q;
    logic [ADDR_W-1:0]   ptr_q;
    logic                wrap_q;
    logic                accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:  if (!fifo_empty) state_d = WR_BURST;
            WR_BURST: if (mem_ready && beat_q == LAST_BEAT) state_d = WR_IDLE;
            default:  state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pop    = 1'b0;
        mem_we = 1'b0;
        unique case (state_q)
            WR_IDLE:  pop    = !fifo_empty;
            WR_BURST: mem_we = 1'b1;
            default:  mem_we = 1'b0;
        endcase
    end

    assign accept    = mem_we && mem_ready;
    assign mem_addr  = ptr_q;
    assign mem_wdata = hold_q[beat_q*BUS_W +: BUS_W];
    assign wrapped   = wrap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            beat_q <= '0;
            ptr_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            if (pop) begin
                hold_q <= HOLD_W'(rec_data);
                beat_q <= '0;
            end
            if (accept) begin
                beat_q <= beat_q + 1'b1;
                ptr_q  <= ptr_q + 1'b1;
                if (&ptr_q) wrap_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/transition_recorder.sv
module transition_recorder #(
    parameter int unsigned NUM_CH     = 20,
    parameter int unsigned CH_W       = 4,
    parameter int unsigned TS_W       = 40,
    parameter int unsigned FIFO_DEPTH = 16,
    parameter int unsigned ADDR_W     = 19,
    parameter int unsigned MISS_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rec_en,
    input  logic [NUM_CH*CH_W-1:0]   state_in,
    input  logic                     mem_ready,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [31:0]              mem_wdata,
    output logic                     fifo_full,
    output logic                     fifo_empty,
    output logic [MISS_W-1:0]        miss_count,
    output logic                     wrapped
);
    localparam int unsigned STATE_W = NUM_CH * CH_W;
    localparam int unsigned REC_RAW = STATE_W + TS_W;
    localparam int unsigned WORDS   = rec_pkg::words_for(REC_RAW);

    logic               evt;
    logic [TS_W-1:0]    ts;
    logic [REC_RAW-1:0] head;
    logic               pop;
    logic [MISS_W-1:0]  miss_q;

    rec_change_detect #(.STATE_W(STATE_W), .TS_W(TS_W)) det_i (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .state_in(state_in),
        .evt(evt), .ts(ts)
    );

    rec_fifo #(.W(REC_RAW), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(evt), .wr_data({ts, state_in}),
        .pop(pop), .rd_data(head), .full(fifo_full), .empty(fifo_empty)
    );

    rec_mem_writer #(.IN_W(REC_RAW), .WORDS(WORDS), .ADDR_W(ADDR_W)) wr_i (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .rec_data(head),
        .pop(pop), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wrapped(wrapped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          miss_q <= '0;
        else if (evt && fifo_full && !(&miss_q)) miss_q <= miss_q + 1'b1;
    end

    assign miss_count = miss_q;
endmodule

// File: rtl/rec_checker.sv
module rec_checker #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_en,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic [MISS_W-1:0] miss_count,
    input logic              wrapped
);
    logic opening_q;

    always_ff @(posedge clk) begin
        if (!rst_n) opening_q <= 1'b1;
        else        opening_q <= 1'b0;
    end

    p_first_rec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        opening_q && rec_en |=> !fifo_empty);

    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    p_miss_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_full |=> $stable(miss_count));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_ready |=> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_ready) |=> $stable(mem_addr));

    p_wrap_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));
endmodule

bind transition_recorder rec_checker #(.ADDR_W(ADDR_W), .MISS_W(MISS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .miss_count(miss_count),
    .wrapped(wrapped)
);

// File: tb/transition_recorder_tb_top.sv
module transition_recorder_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int NUM_CH  = 20;
    localparam int CH_W    = 4;
    localparam int STATE_W = NUM_CH * CH_W;
    localparam int ADDR_W  = 6;
    localparam int MEM_WORDS = 1 << ADDR_W;
    localparam int MISS_W  = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic rec_en;
    logic [STATE_W-1:0] state_in;
    logic mem_ready;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic fifo_full;
    logic fifo_empty;
    logic [MISS_W-1:0] miss_count;
    logic wrapped;

    always #(CLK_PERIOD/2) clk = ~clk;

    transition_recorder #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .TS_W(40), .FIFO_DEPTH(16),
        .ADDR_W(ADDR_W), .MISS_W(MISS_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .state_in(state_in),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .miss_count(miss_count), .wrapped(wrapped)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model state
    logic [127:0]        exp_q[$];
    logic [39:0]         ts_m;
    logic [STATE_W-1:0]  prev_m;
    bit                  first_m;
    int                  miss_m;
    logic [ADDR_W-1:0]   exp_addr;
    int                  words_done;
    int                  wc;
    logic [3:0][31:0]    rbuf;
    bit                  stall_prev;
    logic [ADDR_W-1:0]   last_addr;
    logic [31:0]         last_data;
    int                  writes_seen;
    logic [STATE_W-1:0]  cur;

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [127:0] make_rec(input logic [39:0] t, input logic [STATE_W-1:0] s);
        return {8'h00, t, s};
    endfunction

    task automatic step(input logic en, input logic [STATE_W-1:0] st, input logic rdy);
        rec_en = en;
        state_in = st;
        mem_ready = rdy;
        #1;
        if (stall_prev)
            check(mem_we && mem_addr == last_addr && mem_wdata == last_data,
                  "R10 stalled word held", {mem_addr, mem_wdata}, {last_addr, last_data});
        stall_prev = mem_we && !rdy;
        last_addr  = mem_addr;
        last_data  = mem_wdata;
        check(wrapped == (words_done >= MEM_WORDS), "R8 wrap flag",
              128'(wrapped), 128'(words_done >= MEM_WORDS));
        if (en && (first_m || st != prev_m)) begin
            if (fifo_full) miss_m++;
            else exp_q.push_back(make_rec(ts_m, st));
        end
        if (en) first_m = 1'b0;
        prev_m = st;
        if (mem_we && rdy) begin
            check(mem_addr == exp_addr, "R7 word address", 128'(mem_addr), 128'(exp_addr));
            rbuf[wc] = mem_wdata;
            wc++;
            exp_addr = exp_addr + 1'b1;
            words_done++;
            writes_seen++;
            if (wc == 4) begin
                wc = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected record", rbuf, 128'h0);
                end else begin
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    check(rbuf == e, "R3/R4/R5 record content", rbuf, e);
                end
            end
        end
        ts_m = ts_m + 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [STATE_W-1:0] nudge(input logic [STATE_W-1:0] s);
        logic [STATE_W-1:0] r;
        int ch;
        r = s;
        ch = $urandom_range(0, NUM_CH - 1);
        r[ch*CH_W +: CH_W] = CH_W'($urandom);
        return r;
    endfunction

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0; rec_en = 1'b0; state_in = '0; mem_ready = 1'b0;
        ts_m = '0; prev_m = '0; first_m = 1'b1; miss_m = 0; exp_addr = '0;
        words_done = 0; wc = 0; rbuf = '0; stall_prev = 1'b0;
        last_addr = '0; last_data = '0; writes_seen = 0;
        repeat (3) @(negedge clk);
        check(!mem_we, "R7 reset no write", 128'(mem_we), 128'h0);
        check(fifo_empty && !fifo_full, "R5 reset flags", {fifo_full, fifo_empty}, 128'h1);
        check(miss_count == 0, "R6 reset miss count", 128'(miss_count), 128'h0);
        check(mem_addr == 0 && !wrapped, "R8 reset address and flag", {wrapped, mem_addr}, 128'h0);

        // R1: opening cycle records even an all-zero vector
        rst_n = 1'b1;
        cur = '0;
        step(1'b1, cur, 1'b1);
        check(!fifo_empty, "R1 opening record captured", 128'(fifo_empty), 128'h0);
        repeat (10) step(1'b1, cur, 1'b1);

        // R2: steady vector produces no writes
        writes_seen = 0;
        repeat (30) step(1'b1, cur, 1'b1);
        check(writes_seen == 0, "R2 no write on steady vector", 128'(writes_seen), 128'h0);

        // random traffic, wraps the ring (R7/R8)
        for (int i = 0; i < 800; i++) begin
            logic en;
            logic rdy;
            en  = ($urandom_range(0, 9) != 0);
            rdy = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 4) == 0) cur = nudge(cur);
            step(en, cur, rdy);
        end
        repeat (120) step(1'b0, cur, 1'b1);
        check(words_done >= MEM_WORDS, "R8 ring wrapped during run",
              128'(words_done), 128'(MEM_WORDS));

        // R9: changes while disabled are ignored
        writes_seen = 0;
        for (int i = 0; i < 12; i++) begin
            cur = cur + 1'b1;
            step(1'b0, cur, 1'b1);
        end
        step(1'b1, cur, 1'b1);
        step(1'b1, cur, 1'b1);
        check(fifo_empty && writes_seen == 0, "R9 no record after disabled changes",
              {fifo_empty, 32'(writes_seen)}, {1'b1, 32'h0});
        cur = cur + 1'b1;
        step(1'b1, cur, 1'b1);
        check(!fifo_empty, "R9 change after re-enable recorded", 128'(fifo_empty), 128'h0);
        repeat (20) step(1'b1, cur, 1'b1);

        // R5/R6: fill the FIFO with the memory stalled
        for (int i = 0; i < 24; i++) begin
            cur = cur + 1'b1;
            step(1'b1, cur, 1'b0);
        end
        check(fifo_full, "R5 FIFO full after stalled burst", 128'(fifo_full), 128'h1);
        check(miss_count == MISS_W'(miss_m) && miss_m > 0, "R6 dropped changes counted",
              128'(miss_count), 128'(miss_m));

        // drain and finish
        repeat (150) step(1'b0, cur, ($urandom_range(0, 1) == 1));
        repeat (100) step(1'b0, cur, 1'b1);
        check(fifo_empty && !mem_we, "R5 FIFO drained", {fifo_empty, mem_we}, 128'h2);
        check(exp_q.size() == 0, "R2 all captured records written",
              128'(exp_q.size()), 128'h0);
        check(miss_count == MISS_W'(miss_m), "R6 final miss count",
              128'(miss_count), 128'(miss_m));

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule